// File: doc/BRIEF.md
# Two-Wire ADC Readout and Command Controller

This block sits on the converter side of a single-channel ADC and drives the one pin that the host sees: a combined ready/data line. The host supplies only a serial clock. The block takes a 24-bit two's-complement result and a valid strobe from the conversion engine. When a result is waiting it pulls the line low. Each serial clock rising edge then presents the next bit, starting with the most significant.

The host has no data input, so every command is carried by the serial clock. The number of pulses in a frame selects the command, and so does any hold-high period longer than a programmable count of system clocks. A 25th pulse returns the line high. A 26th pulse starts a self-calibration. A long high phase puts the block to sleep. The next falling edge wakes it, and the block then requests either a restart or a calibration from the conversion engine.

The serial clock passes through a two-flop synchronizer into the system clock domain. A result that arrives in the middle of a frame is held in a shadow register. It is presented when the frame completes.

Top module: `twowire_readout_ctrl`

## Requirements
- R1: During and right after reset the data line is high, `sleep_o` is low and neither request pulses.
- R2: A valid result received while idle drives the data line low within a few system clocks.
- R3: Rising edges 1 to 24 of a frame each present one result bit, bit 23 first and bit 0 last (two's complement).
- R4: After the 24th edge with no further pulses, the line keeps the level of bit 0.
- R5: The 25th rising edge drives the line high.
- R6: The falling edge of the 26th pulse gives a one-cycle `cal_req_o`. The line then stays high until the next result, which drives it low.
- R7: Once the line has gone low, an SCLK high phase longer than `HOLD_CYC` system clocks puts the block to sleep, mid-frame or before any bit is read. `sleep_o` rises and the line is high while asleep.
- R8: SCLK going low during sleep clears `sleep_o` and gives a one-cycle `restart_o`.
- R9: If the 26th pulse is the one held high, waking gives `cal_req_o` instead of `restart_o`.
- R10: A result still waiting unread is replaced by a newer one, and only the newer one is shifted out.
- R11: A result that arrives during bits 1 to 24 does not change the frame in progress. It is presented at the 25th edge, which then drives the line low.
- R12: A long SCLK high phase while no result is waiting does not cause sleep.
- R13: Results that arrive during sleep are dropped, so after waking the line stays high until a new result arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Host serial clock, asynchronous |
| result_i | input | 24 | Conversion result, two's complement |
| result_vld_i | input | 1 | One-cycle strobe: result_i is new |
| rdy_dout_o | output | 1 | Ready (low) / serial data line |
| cal_req_o | output | 1 | One-cycle self-calibration request |
| restart_o | output | 1 | One-cycle conversion restart request after wake |
| sleep_o | output | 1 | High while the engine should sleep |

## Verification
The hardest case to reach is the calibration-on-wake path. It needs a complete 24-bit read, a clean 25th pulse, and a 26th pulse whose high phase outlasts the hold limit, all in one frame. A scoreboard checks every bit of that frame on the way. The bench then compares the request counters to tell calibration apart from restart. The shadow path is reached in the same way: a second result is injected after ten bits of a frame have been shifted. The scoreboard confirms that the old bits finish unchanged and that the new result starts right after the 25th edge.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [1:0] {
    TW_IDLE  = 2'd0,
    TW_READY = 2'd1,
    TW_SHIFT = 2'd2,
    TW_SLEEP = 2'd3
  } tw_state_e;
endpackage

// File: rtl/tw_sclk_sync.sv
module tw_sclk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  output logic sclk_s_o,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= sclk_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sclk_s_o = sync_q;
  assign rise_o   = sync_q & ~prev_q;
  assign fall_o   = ~sync_q & prev_q;
endmodule

// File: rtl/tw_hold_timer.sv
module tw_hold_timer #(
  parameter int HOLD_CYC = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic expired_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!level_i)           cnt_d = '0;
    else if (cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == LIMIT);
endmodule

// File: rtl/tw_result_store.sv
module tw_result_store #(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din_i,
  input  logic              ld_in_i,
  input  logic              ld_sh_i,
  input  logic              st_sh_i,
  input  logic              clr_sh_i,
  input  logic [CNT_W-1:0]  pos_i,
  output logic              sh_vld_o,
  output logic              bit_o
);
  logic [DATA_W-1:0] cur_q, sh_q;
  logic              sh_vld_q;
  logic              cur_en, sh_en;
  logic [DATA_W-1:0] cur_d;

  assign cur_en = ld_in_i | ld_sh_i;
  assign cur_d  = ld_in_i ? din_i : sh_q;
  assign sh_en  = st_sh_i & ~clr_sh_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q    <= '0;
      sh_q     <= '0;
      sh_vld_q <= 1'b0;
    end else begin
      if (cur_en) cur_q <= cur_d;
      if (sh_en)  sh_q  <= din_i;
      if (clr_sh_i | ld_sh_i | ld_in_i) sh_vld_q <= 1'b0;
      else if (sh_en)                   sh_vld_q <= 1'b1;
    end
  end

  always_comb begin
    int idx;
    idx   = DATA_W - int'(pos_i);
    bit_o = 1'b1;
    if (idx >= 0 && idx < DATA_W) bit_o = cur_q[idx];
  end

  assign sh_vld_o = sh_vld_q;
endmodule

// File: rtl/tw_mode_fsm.sv
module tw_mode_fsm
  import tw_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             held_i,
  input  logic             vld_i,
  input  logic             sh_vld_i,
  output tw_state_e        state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ld_in_o,
  output logic             ld_sh_o,
  output logic             st_sh_o,
  output logic             clr_sh_o,
  output logic             cal_req_o,
  output logic             restart_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] END_PULSE = CNT_W'(DATA_W + 1);
  localparam logic [CNT_W-1:0] CAL_PULSE = CNT_W'(DATA_W + 2);

  tw_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wake_cal_q, wake_cal_d;
  logic             cal_d, rst_d, cal_q, rstr_q;

  always_comb begin
    state_d    = state_q;
    cnt_d      = cnt_q;
    wake_cal_d = wake_cal_q;
    ld_in_o    = 1'b0;
    ld_sh_o    = 1'b0;
    st_sh_o    = 1'b0;
    clr_sh_o   = 1'b0;
    cal_d      = 1'b0;
    rst_d      = 1'b0;
    unique case (state_q)
      TW_IDLE: begin
        if (vld_i) begin
          ld_in_o = 1'b1;
          state_d = TW_READY;
          cnt_d   = '0;
        end
      end
      TW_READY: begin
        if (held_i) begin
          state_d    = TW_SLEEP;
          clr_sh_o   = 1'b1;
          wake_cal_d = 1'b0;
        end else if (rise_i) begin
          state_d = TW_SHIFT;
          cnt_d   = 1;
          st_sh_o = vld_i;
        end else if (vld_i) begin
          ld_in_o = 1'b1;
        end
      end
      TW_SHIFT: begin
        if (held_i) begin
          state_d    = TW_SLEEP;
          clr_sh_o   = 1'b1;
          wake_cal_d = (cnt_q == CAL_PULSE);
        end else if (rise_i) begin
          if (cnt_q == LAST_BIT) begin
            if (vld_i || sh_vld_i) begin
              ld_in_o = vld_i;
              ld_sh_o = ~vld_i;
              state_d = TW_READY;
              cnt_d   = '0;
            end else begin
              cnt_d = END_PULSE;
            end
          end else begin
            cnt_d   = cnt_q + 1'b1;
            st_sh_o = vld_i;
          end
        end else if (fall_i && cnt_q == CAL_PULSE) begin
          cal_d    = 1'b1;
          clr_sh_o = 1'b1;
          state_d  = TW_IDLE;
        end else if (vld_i) begin
          if (cnt_q == END_PULSE) begin
            ld_in_o = 1'b1;
            state_d = TW_READY;
            cnt_d   = '0;
          end else begin
            st_sh_o = 1'b1;
          end
        end
      end
      TW_SLEEP: begin
        if (fall_i) begin
          cal_d      = wake_cal_q;
          rst_d      = ~wake_cal_q;
          wake_cal_d = 1'b0;
          state_d    = TW_IDLE;
        end
      end
      default: state_d = TW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TW_IDLE;
      cnt_q      <= '0;
      wake_cal_q <= 1'b0;
      cal_q      <= 1'b0;
      rstr_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cnt_q      <= cnt_d;
      wake_cal_q <= wake_cal_d;
      cal_q      <= cal_d;
      rstr_q     <= rst_d;
    end
  end

  assign state_o   = state_q;
  assign cnt_o     = cnt_q;
  assign cal_req_o = cal_q;
  assign restart_o = rstr_q;
endmodule

// File: rtl/twowire_readout_ctrl.sv
module twowire_readout_ctrl
  import tw_pkg::*;
#(
  parameter int DATA_W   = 24,
  parameter int HOLD_CYC = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  input  logic              result_vld_i,
  output logic              rdy_dout_o,
  output logic              cal_req_o,
  output logic              restart_o,
  output logic              sleep_o
);
  localparam int CNT_W = $clog2(DATA_W + 3);

  logic             sclk_s, rise, fall, held;
  logic             ld_in, ld_sh, st_sh, clr_sh, sh_vld, bit_sel;
  tw_state_e        state;
  logic [CNT_W-1:0] cnt;

  tw_sclk_sync u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i),
    .sclk_s_o(sclk_s), .rise_o(rise), .fall_o(fall)
  );

  tw_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .level_i(sclk_s), .expired_o(held)
  );

  tw_result_store #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst_n(rst_n), .din_i(result_i),
    .ld_in_i(ld_in), .ld_sh_i(ld_sh), .st_sh_i(st_sh), .clr_sh_i(clr_sh),
    .pos_i(cnt), .sh_vld_o(sh_vld), .bit_o(bit_sel)
  );

  tw_mode_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall), .held_i(held),
    .vld_i(result_vld_i), .sh_vld_i(sh_vld), .state_o(state), .cnt_o(cnt),
    .ld_in_o(ld_in), .ld_sh_o(ld_sh), .st_sh_o(st_sh), .clr_sh_o(clr_sh),
    .cal_req_o(cal_req_o), .restart_o(restart_o)
  );

  always_comb begin
    unique case (state)
      TW_READY: rdy_dout_o = 1'b0;
      TW_SHIFT: rdy_dout_o = bit_sel;
      default:  rdy_dout_o = 1'b1;
    endcase
  end

  assign sleep_o = (state == TW_SLEEP);
endmodule

// File: rtl/tw_readout_chk.sv
module tw_readout_chk (
  input logic clk,
  input logic rst_n,
  input logic rdy_dout_o,
  input logic cal_req_o,
  input logic restart_o,
  input logic sleep_o
);
  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_idle_R1: assert (rdy_dout_o && !sleep_o && !cal_req_o && !restart_o);
    end
  end

  assert_sleep_line_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_o |-> rdy_dout_o);

  assert_wake_request_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sleep_o) |-> (cal_req_o ^ restart_o));

  assert_restart_from_sleep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |-> $past(sleep_o));

  assert_cal_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cal_req_o |=> !cal_req_o);

  assert_requests_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cal_req_o, restart_o}));
endmodule

bind twowire_readout_ctrl tw_readout_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rdy_dout_o(rdy_dout_o),
  .cal_req_o(cal_req_o), .restart_o(restart_o), .sleep_o(sleep_o)
);

// File: tb/twowire_readout_ctrl_bench.sv
module twowire_readout_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int LONG       = 150;

  logic        clk, rst_n, sclk_i, result_vld_i;
  logic [23:0] result_i;
  logic        rdy_dout_o, cal_req_o, restart_o, sleep_o;

  int checks = 0;
  int failures = 0;
  int cal_cnt = 0;
  int rst_cnt = 0;
  bit exp_q[$];
  string req_q[$];
  event smp_ev;

  twowire_readout_ctrl u_twowire_readout_ctrl (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .result_i(result_i),
    .result_vld_i(result_vld_i), .rdy_dout_o(rdy_dout_o),
    .cal_req_o(cal_req_o), .restart_o(restart_o), .sleep_o(sleep_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (cal_req_o) cal_cnt <= cal_cnt + 1;
    if (restart_o) rst_cnt <= rst_cnt + 1;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(smp_ev);
      if (exp_q.size() > 0) chk(req_q.pop_front(), int'(rdy_dout_o), int'(exp_q.pop_front()));
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [23:0] d);
    @(negedge clk);
    result_i = d;
    result_vld_i = 1'b1;
    @(negedge clk);
    result_vld_i = 1'b0;
  endtask

  task automatic pulse(bit expv, string req);
    sclk_i = 1'b1;
    tick(HALF);
    exp_q.push_back(expv);
    req_q.push_back(req);
    -> smp_ev;
    tick(1);
    sclk_i = 1'b0;
    tick(HALF);
  endtask

  task automatic shift_bits(logic [23:0] d, int first, int n, string req);
    for (int i = first; i < first + n; i++) pulse(d[23-i], req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sclk_i = 1'b0; result_i = '0; result_vld_i = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(3);
    chk("R1 line", int'(rdy_dout_o), 1);
    chk("R1 sleep", int'(sleep_o), 0);
    chk("R1 req", cal_cnt + rst_cnt, 0);

    // R2/R3/R4/R5: plain read
    load(24'hA5C396);
    tick(4);
    chk("R2 ready low", int'(rdy_dout_o), 0);
    shift_bits(24'hA5C396, 0, 24, "R3");
    tick(20);
    chk("R4 hold D0", int'(rdy_dout_o), 0);
    pulse(1'b1, "R5 25th");
    tick(10);
    chk("R5 idle high", int'(rdy_dout_o), 1);

    // R10: overwrite unread
    load(24'h123456);
    tick(3);
    load(24'h800001);
    tick(3);
    shift_bits(24'h800001, 0, 24, "R10");
    pulse(1'b1, "R5 25th");

    // R11: result during frame
    load(24'h7FFFFE);
    tick(4);
    shift_bits(24'h7FFFFE, 0, 10, "R11 old");
    load(24'h0F0F0F);
    shift_bits(24'h7FFFFE, 10, 14, "R11 old");
    pulse(1'b0, "R11 new ready");
    shift_bits(24'h0F0F0F, 0, 24, "R11 new");
    pulse(1'b1, "R5 25th");

    // R6: 26th pulse calibration
    load(24'h000001);
    tick(4);
    shift_bits(24'h000001, 0, 24, "R3");
    pulse(1'b1, "R5 25th");
    pulse(1'b1, "R6 26th");
    tick(4);
    chk("R6 cal pulse", cal_cnt, 1);
    chk("R6 line high", int'(rdy_dout_o), 1);
    // R12: long high while idle
    sclk_i = 1'b1;
    tick(LONG);
    chk("R12 no sleep", int'(sleep_o), 0);
    sclk_i = 1'b0;
    tick(6);
    chk("R12 no restart", rst_cnt, 0);
    load(24'h3C3C3C);
    tick(4);
    chk("R6 next ready", int'(rdy_dout_o), 0);

    // R7/R8/R13: sleep mid-frame
    shift_bits(24'h3C3C3C, 0, 5, "R3");
    sclk_i = 1'b1;
    tick(LONG);
    chk("R7 sleep", int'(sleep_o), 1);
    chk("R7 line", int'(rdy_dout_o), 1);
    load(24'h111111);
    sclk_i = 1'b0;
    tick(6);
    chk("R8 awake", int'(sleep_o), 0);
    chk("R8 restart", rst_cnt, 1);
    chk("R8 no cal", cal_cnt, 1);
    tick(20);
    chk("R13 dropped", int'(rdy_dout_o), 1);
    load(24'h222222);
    tick(4);
    chk("R8 ready", int'(rdy_dout_o), 0);

    // R7: sleep before any bit
    sclk_i = 1'b1;
    tick(LONG);
    chk("R7 sleep unread", int'(sleep_o), 1);
    sclk_i = 1'b0;
    tick(6);
    chk("R8 restart2", rst_cnt, 2);

    // R9: 26th held high
    load(24'hFFFFFF);
    tick(4);
    shift_bits(24'hFFFFFF, 0, 24, "R3");
    pulse(1'b1, "R5 25th");
    sclk_i = 1'b1;
    tick(LONG);
    chk("R9 sleep", int'(sleep_o), 1);
    sclk_i = 1'b0;
    tick(6);
    chk("R9 cal", cal_cnt, 2);
    chk("R9 no restart", rst_cnt, 2);
    load(24'h000002);
    tick(4);
    chk("R9 ready", int'(rdy_dout_o), 0);

    tick(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule